// File: doc/BRIEF.md
# DMA Channel Event Latch and Dispatcher

This block is the trigger front end of a multi-channel DMA controller. Each channel owns one bit in a pending word. A pending bit is raised by a rising edge on that channel's hardware event line, by software through a write-one-to-set register, or by the completion of another channel that is configured to chain into it. Software can drop pending bits through a write-one-to-clear register. An enable word, which has its own set and clear addresses, decides which pending bits may be dispatched.

Among the channels that are both pending and enabled, the dispatcher presents one channel to the transfer engine on a request/acknowledge handshake. The choice goes to the highest programmed priority level, and among channels on the same level the lowest channel number wins. The acknowledged channel's pending bit is removed in the acknowledge cycle. Each channel has an option word that holds its priority, a chain-enable flag and a chain target. A completion reported on a chaining channel raises the target's pending bit and leaves every option word as it was.

Top module: `dma_evt_dispatch`

## Requirements
- R1: A 0-to-1 transition on `evtIn[n]` sets pending bit n at the next rising clock edge. An event line that stays high sets the bit only once.
- R2: A write to address 1 sets every pending bit whose data bit is one.
- R3: A write to address 2 clears every pending bit whose data bit is one. Data bits that are zero leave their pending bits unchanged.
- R4: When an event edge and an address-2 clear hit the same bit in the same cycle, the bit ends up set.
- R5: The enable word reads at address 3. A write to address 4 sets the enable bits whose data bits are one, and a write to address 5 clears them.
- R6: `reqValid` is high exactly when at least one channel is both pending and enabled, and `reqCh` then names such a channel.
- R7: The priority level is bits [1:0] of a channel's option word, and 3 is the most urgent. The highest level wins, and among equal levels the lowest channel number wins.
- R8: A cycle with `reqValid` and `reqAck` both high clears the pending bit of `reqCh` at that clock edge.
- R9: When option bit 8 of channel c is set, a cycle with `cplValid` high and `cplCh` equal to c sets the pending bit of the channel held in option bits [21:16] of c. Channels with bit 8 clear raise nothing, and no option word changes.
- R10: Channel n's option word is written and read at address 64+n.
- R11: After reset the pending word, the enable word and all option words read zero, and `reqValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 64 | Hardware event lines, one per channel |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 7 | Register write address |
| wrData | input | 64 | Register write data |
| rdAddr | input | 7 | Register read address |
| rdData | output | 64 | Register read data (combinational) |
| cplValid | input | 1 | Completion report valid |
| cplCh | input | 6 | Channel that completed |
| reqValid | output | 1 | Dispatch request |
| reqCh | output | 6 | Channel being dispatched |
| reqAck | input | 1 | Transfer engine accepts the request |

## Verification
Every state change (an event edge, a register write, an acknowledge or a completion) lands on the first rising edge after the stimulus is driven. The read port and the request outputs then follow with no further delay. The bench drives each stimulus on a falling edge, lets exactly one rising edge pass, and samples `rdData`, `reqValid` and `reqCh` at the following falling edge, so each result is read one edge after its cause. Same-cycle collisions, namely an event edge against a clear, are set up by driving both inputs on the same falling edge.

// File: rtl/dma_evt_pkg.sv
package dma_evt_pkg;
  localparam int ADR_PEND     = 0;
  localparam int ADR_PEND_SET = 1;
  localparam int ADR_PEND_CLR = 2;
  localparam int ADR_EN       = 3;
  localparam int ADR_EN_SET   = 4;
  localparam int ADR_EN_CLR   = 5;
  localparam int OPT_CHAIN_BIT = 8;
  localparam int OPT_TGT_LSB   = 16;

  typedef struct packed {
    logic pendSet;
    logic pendClr;
    logic enSet;
    logic enClr;
    logic optWr;
    logic ack;
  } strobe_t;
endpackage

// File: rtl/dma_evt_ctrl.sv
module dma_evt_ctrl
  import dma_evt_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ADDR_W = IDX_W + 1
)(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              reqValid,
  input  logic              reqAck,
  output strobe_t           stb
);
  always_comb begin
    stb.pendSet = wrEn && (wrAddr == ADDR_W'(ADR_PEND_SET));
    stb.pendClr = wrEn && (wrAddr == ADDR_W'(ADR_PEND_CLR));
    stb.enSet   = wrEn && (wrAddr == ADDR_W'(ADR_EN_SET));
    stb.enClr   = wrEn && (wrAddr == ADDR_W'(ADR_EN_CLR));
    stb.optWr   = wrEn && wrAddr[IDX_W];
    stb.ack     = reqValid && reqAck;
  end
endmodule

// File: rtl/dma_evt_datapath.sv
module dma_evt_datapath
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = $clog2(NUM_CH),
  parameter int ADDR_W = IDX_W + 1,
  parameter int DATA_W = NUM_CH
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        evtIn,
  input  strobe_t                  stb,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [ADDR_W-1:0]        rdAddr,
  output logic [DATA_W-1:0]        rdData,
  input  logic                     cplValid,
  input  logic [IDX_W-1:0]         cplCh,
  input  logic                     reqValid,
  input  logic [IDX_W-1:0]         reqCh,
  output logic [NUM_CH-1:0]        pending,
  output logic [NUM_CH-1:0]        enable,
  output logic [NUM_CH*PRIO_W-1:0] prioFlat
);
  logic [NUM_CH-1:0] evtPrev, rise, chainMask, ackMask, setMask, clrMask;
  logic [NUM_CH-1:0] chainEn;
  logic [PRIO_W-1:0] prio     [NUM_CH];
  logic [IDX_W-1:0]  chainTgt [NUM_CH];
  logic [IDX_W-1:0]  optIdx, rdIdx;

  assign optIdx = wrAddr[IDX_W-1:0];
  assign rdIdx  = rdAddr[IDX_W-1:0];
  assign rise   = evtIn & ~evtPrev;
  assign setMask = stb.pendSet ? wrData[NUM_CH-1:0] : '0;
  assign clrMask = stb.pendClr ? wrData[NUM_CH-1:0] : '0;

  always_comb begin
    chainMask = '0;
    if (cplValid && chainEn[cplCh]) chainMask[chainTgt[cplCh]] = 1'b1;
    ackMask = '0;
    if (stb.ack) ackMask[reqCh] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtPrev <= '0;
      pending <= '0;
      enable  <= '0;
    end else begin
      evtPrev <= evtIn;
      pending <= (pending & ~clrMask & ~ackMask) | setMask | rise | chainMask;
      if (stb.enSet) enable <= enable | wrData[NUM_CH-1:0];
      if (stb.enClr) enable <= enable & ~wrData[NUM_CH-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chainEn <= '0;
      for (int i = 0; i < NUM_CH; i++) begin
        prio[i]     <= '0;
        chainTgt[i] <= '0;
      end
    end else if (stb.optWr) begin
      prio[optIdx]     <= wrData[PRIO_W-1:0];
      chainEn[optIdx]  <= wrData[OPT_CHAIN_BIT];
      chainTgt[optIdx] <= wrData[OPT_TGT_LSB +: IDX_W];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign prioFlat[g*PRIO_W +: PRIO_W] = prio[g];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr[IDX_W]) begin
      rdData[PRIO_W-1:0]          = prio[rdIdx];
      rdData[OPT_CHAIN_BIT]       = chainEn[rdIdx];
      rdData[OPT_TGT_LSB +: IDX_W] = chainTgt[rdIdx];
    end else if (rdAddr == ADDR_W'(ADR_PEND)) begin
      rdData[NUM_CH-1:0] = pending;
    end else if (rdAddr == ADDR_W'(ADR_EN)) begin
      rdData[NUM_CH-1:0] = enable;
    end
  end

  a_r1_event_latched: assert property (@(posedge clk) disable iff (!rstN)
    (|rise) |=> ((pending & $past(rise)) == $past(rise)));

  a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendClr && !(|rise) && !cplValid && !stb.pendSet)
      |=> ((pending & $past(wrData[NUM_CH-1:0])) == '0));

  a_r4_event_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendClr && |(rise & wrData[NUM_CH-1:0]))
      |=> ((pending & $past(rise & wrData[NUM_CH-1:0])) == $past(rise & wrData[NUM_CH-1:0])));

  a_r5_enable_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.enClr |=> ((enable & $past(wrData[NUM_CH-1:0])) == '0));

  a_r6_req_is_live: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (pending[reqCh] && enable[reqCh]));

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !rise[reqCh] && !chainMask[reqCh] && !setMask[reqCh])
      |=> !pending[$past(reqCh)]);
endmodule

// File: rtl/dma_evt_arbiter.sv
module dma_evt_arbiter #(
  parameter int NUM_CH = 64,
  parameter int PRIO_W = 2,
  parameter int IDX_W  = $clog2(NUM_CH)
)(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH-1:0]        pending,
  input  logic [NUM_CH-1:0]        enable,
  input  logic [NUM_CH*PRIO_W-1:0] prioFlat,
  output logic                     reqValid,
  output logic [IDX_W-1:0]         reqCh
);
  logic [NUM_CH-1:0] cand;
  logic [PRIO_W-1:0] prio [NUM_CH];
  logic [PRIO_W-1:0] bestP;
  logic              found;

  assign cand = pending & enable;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_unflat
    assign prio[g] = prioFlat[g*PRIO_W +: PRIO_W];
  end

  // Descending scan with >= so the lowest index keeps a tied level.
  always_comb begin
    found = 1'b0;
    bestP = '0;
    reqCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (cand[i] && (!found || prio[i] >= bestP)) begin
        found = 1'b1;
        bestP = prio[i];
        reqCh = IDX_W'(i);
      end
    end
  end
  assign reqValid = found;

  // Independent reference: highest level first, then first index on it.
  logic [PRIO_W-1:0] refMax;
  logic [IDX_W-1:0]  refIdx;
  logic              refAny, refHit;
  always_comb begin
    refMax = '0;
    refAny = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (cand[i]) begin
        refAny = 1'b1;
        if (prio[i] > refMax) refMax = prio[i];
      end
    end
    refIdx = '0;
    refHit = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (!refHit && cand[i] && prio[i] == refMax) begin
        refHit = 1'b1;
        refIdx = IDX_W'(i);
      end
    end
  end

  a_r6_valid_iff_candidate: assert property (@(posedge clk) disable iff (!rstN)
    reqValid == refAny);

  a_r7_winner_order: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqCh == refIdx));
endmodule

// File: rtl/dma_evt_dispatch.sv
module dma_evt_dispatch
  import dma_evt_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int PRIO_W = 2,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int ADDR_W = IDX_W + 1,
  localparam int DATA_W = NUM_CH
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] evtIn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              cplValid,
  input  logic [IDX_W-1:0]  cplCh,
  output logic              reqValid,
  output logic [IDX_W-1:0]  reqCh,
  input  logic              reqAck
);
  strobe_t                  stb;
  logic [NUM_CH-1:0]        pending, enable;
  logic [NUM_CH*PRIO_W-1:0] prioFlat;

  dma_evt_ctrl #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .reqValid(reqValid), .reqAck(reqAck), .stb(stb)
  );

  dma_evt_datapath #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W),
                     .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .stb(stb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .cplValid(cplValid), .cplCh(cplCh), .reqValid(reqValid), .reqCh(reqCh),
    .pending(pending), .enable(enable), .prioFlat(prioFlat)
  );

  dma_evt_arbiter #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rstN(rstN), .pending(pending), .enable(enable),
    .prioFlat(prioFlat), .reqValid(reqValid), .reqCh(reqCh)
  );
endmodule

// File: tb/sim_dma_evt_dispatch.sv
module sim_dma_evt_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] evtIn = '0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [63:0] wrData = '0;
  logic [6:0]  rdAddr = '0;
  logic [63:0] rdData;
  logic        cplValid = 1'b0;
  logic [5:0]  cplCh = '0;
  logic        reqValid;
  logic [5:0]  reqCh;
  logic        reqAck = 1'b0;

  int testCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_evt_dispatch u0 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .cplValid(cplValid),
    .cplCh(cplCh), .reqValid(reqValid), .reqCh(reqCh), .reqAck(reqAck)
  );

  typedef struct packed {
    logic        isRead;
    logic [6:0]  addr;
    logic [63:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 7'd4,  64'hF0,  8'd5},   // R5 enable set
    '{1'b1, 7'd3,  64'hF0,  8'd5},
    '{1'b0, 7'd4,  64'h03,  8'd5},
    '{1'b1, 7'd3,  64'hF3,  8'd5},
    '{1'b0, 7'd5,  64'h10,  8'd5},   // R5 enable clear
    '{1'b1, 7'd3,  64'hE3,  8'd5},
    '{1'b0, 7'd1,  64'h05,  8'd2},   // R2 pending set
    '{1'b1, 7'd0,  64'h05,  8'd2},
    '{1'b0, 7'd2,  64'h04,  8'd3},   // R3 pending clear
    '{1'b1, 7'd0,  64'h01,  8'd3},
    '{1'b0, 7'd2,  64'h00,  8'd3},   // R3 zeros do nothing
    '{1'b1, 7'd0,  64'h01,  8'd3},
    '{1'b0, 7'd2,  64'h01,  8'd3},
    '{1'b1, 7'd0,  64'h00,  8'd3},
    '{1'b0, 7'd69, 64'h02,  8'd10},  // R10 option word of channel 5
    '{1'b1, 7'd69, 64'h02,  8'd10}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [63:0] exp);
    rdAddr = a;
    #1;
    chk(req, rdData, exp);
  endtask

  task automatic ack();
    @(negedge clk);
    reqAck = 1'b1;
    @(negedge clk);
    reqAck = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    rd("R11", 7'd0, 64'h0);
    rd("R11", 7'd3, 64'h0);
    rd("R11", 7'd69, 64'h0);
    chk("R11", {63'h0, reqValid}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].isRead) rd($sformatf("R%0d", VECS[i].req), VECS[i].addr, VECS[i].data);
      else wr(VECS[i].addr, VECS[i].data);
    end
    // enable = E3, pending = 0

    // R1 edge on channel 7
    @(negedge clk); evtIn[7] = 1'b1;
    @(negedge clk);
    rd("R1", 7'd0, 64'h80);
    chk("R6", {57'h0, reqValid, reqCh}, {57'h0, 1'b1, 6'd7});
    wr(7'd2, 64'h80);
    @(negedge clk);
    rd("R1", 7'd0, 64'h0);  // level held high: no second set

    // R4 event and clear collide on channel 9
    @(negedge clk);
    evtIn[9] = 1'b1; wrEn = 1'b1; wrAddr = 7'd2; wrData = 64'h200;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    rd("R4", 7'd0, 64'h200);
    chk("R6", {63'h0, reqValid}, 64'h0);  // channel 9 not enabled
    wr(7'd4, 64'h200);
    chk("R6", {57'h0, reqValid, reqCh}, {57'h0, 1'b1, 6'd9});

    // R7 priority levels and tie break
    wr(7'd84, 64'h3);
    wr(7'd94, 64'h3);
    wr(7'd4, (64'h1 << 20) | (64'h1 << 30));
    wr(7'd1, (64'h1 << 20) | (64'h1 << 30));
    chk("R7", {58'h0, reqCh}, 64'd20);

    // R8 acknowledge removes the winner
    ack();
    rd("R8", 7'd0, (64'h1 << 9) | (64'h1 << 30));
    chk("R8", {58'h0, reqCh}, 64'd30);
    ack();
    chk("R8", {58'h0, reqCh}, 64'd9);
    ack();
    chk("R8", {63'h0, reqValid}, 64'h0);
    rd("R8", 7'd0, 64'h0);

    // R9 chaining from channel 40 into 41
    wr(7'd104, (64'h1 << 8) | (64'd41 << 16));
    @(negedge clk); cplValid = 1'b1; cplCh = 6'd40;
    @(negedge clk); cplValid = 1'b0;
    rd("R9", 7'd0, 64'h1 << 41);
    rd("R9", 7'd104, (64'h1 << 8) | (64'd41 << 16));
    @(negedge clk); cplValid = 1'b1; cplCh = 6'd5;
    @(negedge clk); cplValid = 1'b0;
    rd("R9", 7'd0, 64'h1 << 41);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      testCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule